// File: doc/BRIEF.md
# Dual-Channel Input Capture Unit

This block records when events happen. It has a shared 16-bit free-running counter and two capture channels. Each channel watches one external pin. When the chosen edge arrives, the channel copies the counter into its own 16-bit capture register and raises its flag. The counter advances once every 2, 4 or 8 system clocks, so one count is the timing resolution.

Software reaches the block over an 8-bit register bus with a 3-bit address. It reads the 16-bit capture values one byte at a time. Reading the high byte freezes that channel until its low byte is read, so the two bytes always belong to the same capture. A flag clears only through a fixed sequence: a status read while the flag is set, then an access to the channel's low byte. One interrupt line serves both channels. It is gated by an enable bit and by a global mask input. A mode input turns off channel 1 captures when the pin serves a pulse-generation mode elsewhere.

Register map (address: content):
- 0, control, read/write: bit 0 is the channel 1 edge, bit 1 the channel 2 edge (1 rising, 0 falling); bits 3:2 are the counter rate; bit 4 is the interrupt enable; bits 7:5 read as 0.
- 1, status, read: bit 0 is the channel 1 flag, bit 1 the channel 2 flag.
- 2 and 3: channel 1 capture, high and low byte.
- 4 and 5: channel 2 capture, high and low byte.

Top module: `icap_dual`

## Requirements
- R1: After reset the counter holds 0xFFFC. It advances by one (wrapping at 16 bits) every N system clocks, where control bits 3:2 give N: 00 gives 4, 01 gives 2, 10 gives 8, and 11 gives 8.
- R2: A pin goes through two synchronizing flops. A level the pin has at clock edge k is compared with the previous synchronized level at edge k+2. On a match that edge stores the counter value held just before it. A control edge bit of 1 selects rising edges and 0 selects falling edges.
- R3: A transition of the non-selected polarity causes no capture and sets no flag.
- R4: A capture sets that channel's status flag (bit 0 for channel 1, bit 1 for channel 2). The capture register always holds the most recent capture.
- R5: A flag clears only when the status register is read while the flag is set and a later cycle then reads or writes that channel's low byte. A low-byte access with no such earlier status read leaves the flag set.
- R6: A read of a channel's high byte locks that channel until its low byte is read. While locked, and in the cycle of the high read itself, edges neither change the capture register nor set the flag.
- R7: If a capture and a flag-clearing low-byte access fall in the same cycle, the flag stays set and the register takes the new value.
- R8: irq is high exactly when a flag is set, control bit 4 is 1 and irq_mask is 0. A flag that is set stays pending while the interrupt is masked or disabled.
- R9: While pulse_mode is 1, channel 1 never captures. Channel 2 captures normally.
- R10: Writes to the capture byte addresses (2 to 5) do not change the capture registers.
- R11: Reset clears the control register, both flags and both capture registers, and drives irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Channel 1 capture pin (asynchronous) |
| pin_b | input | 1 | Channel 2 capture pin (asynchronous) |
| pulse_mode | input | 1 | 1 disables channel 1 capture |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks irq |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe, side effects at the clock edge |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq | output | 1 | Capture interrupt request |

## Verification
The hardest case to reach is a capture that lands in exactly the cycle of the flag-clearing low-byte read. The stimulus arms the flag with a status read first. It then starts a pin edge and issues the low-byte read so that the read falls on the third clock edge after the pin change. The lock window is reached the same way: a high-byte read comes first, and a full selected edge is driven before the low byte is read. Randomized rounds vary the channel, the polarity, the counter rate and the delay. A bench-side counter model with a short history supplies the expected capture value.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int CNT_W       = 16;
    localparam int N_CH        = 2;
    localparam int SYNC_STAGES = 2;
    localparam int PRE_W       = 3;
    localparam logic [CNT_W-1:0] CNT_RST = 16'hFFFC;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        A_CTRL    = 3'd0,
        A_STAT    = 3'd1,
        A_CAP1_HI = 3'd2,
        A_CAP1_LO = 3'd3,
        A_CAP2_HI = 3'd4,
        A_CAP2_LO = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [2:0]      rsvd;
        logic            ien;
        logic [1:0]      clk_sel;
        logic [N_CH-1:0] edge_rise;
    } ctrl_t;

    typedef struct packed {
        logic rd_hi;
        logic rd_lo;
        logic acc_lo;
        logic stat_rd;
    } ch_bus_t;

    function automatic logic [PRE_W:0] div_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 4'd4;
            2'b01:   return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [2:0] hi_addr(input int ch);
        return (ch == 0) ? A_CAP1_HI : A_CAP2_HI;
    endfunction

    function automatic logic [2:0] lo_addr(input int ch);
        return (ch == 0) ? A_CAP1_LO : A_CAP2_LO;
    endfunction

endpackage

// File: rtl/icap_counter.sv
module icap_counter
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] clk_sel,
    output cnt_t       cnt
);

    logic [PRE_W-1:0] pre;
    logic [PRE_W:0]   lim;
    logic             wrap;

    assign lim  = div_of(clk_sel) - 4'd1;
    assign wrap = ({1'b0, pre} >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
            cnt <= CNT_RST;
        end else if (wrap) begin
            pre <= '0;
            cnt <= cnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int SYNC = SYNC_STAGES
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin,
    input  logic    edge_rise,
    input  logic    enable,
    input  cnt_t    cnt,
    input  ch_bus_t bus,
    output cnt_t    cap,
    output logic    flag,
    output logic    lock,
    output logic    stb
);

    logic [SYNC:0] sh;
    logic          cur, prev, hit, arm;

    assign cur  = sh[SYNC-1];
    assign prev = sh[SYNC];
    assign hit  = enable && (edge_rise ? (cur && !prev) : (!cur && prev));
    // the high-byte read cycle is blocked too, so the low byte stays paired
    assign stb  = hit && !lock && !bus.rd_hi;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC-1:0], pin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap  <= '0;
            flag <= 1'b0;
            lock <= 1'b0;
            arm  <= 1'b0;
        end else begin
            if (stb) cap <= cnt;

            if (bus.rd_lo)      lock <= 1'b0;
            else if (bus.rd_hi) lock <= 1'b1;

            if (bus.acc_lo)                 arm <= 1'b0;
            else if (bus.stat_rd && flag)   arm <= 1'b1;

            if (stb)                        flag <= 1'b1;
            else if (bus.acc_lo && arm)     flag <= 1'b0;
        end
    end

endmodule

// File: rtl/icap_dual.sv
module icap_dual
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_a,
    input  logic       pin_b,
    input  logic       pulse_mode,
    input  logic       irq_mask,
    input  logic [2:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);

    ctrl_t           ctrl_q;
    cnt_t            cnt;
    cnt_t            cap [N_CH];
    logic [N_CH-1:0] pins, en, flag, lock, stb;
    ch_bus_t         bus [N_CH];

    assign pins = {pin_b, pin_a};
    assign en   = {1'b1, !pulse_mode};

    always_ff @(posedge clk) begin
        if (rst)                           ctrl_q <= '0;
        else if (wr_en && addr == A_CTRL)  ctrl_q <= ctrl_t'({3'b000, wdata[4:0]});
    end

    icap_counter i_counter (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (ctrl_q.clk_sel),
        .cnt     (cnt)
    );

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
        assign bus[gi].rd_hi   = rd_en && (addr == hi_addr(gi));
        assign bus[gi].rd_lo   = rd_en && (addr == lo_addr(gi));
        assign bus[gi].acc_lo  = (rd_en || wr_en) && (addr == lo_addr(gi));
        assign bus[gi].stat_rd = rd_en && (addr == A_STAT);

        icap_channel i_ch (
            .clk       (clk),
            .rst       (rst),
            .pin       (pins[gi]),
            .edge_rise (ctrl_q.edge_rise[gi]),
            .enable    (en[gi]),
            .cnt       (cnt),
            .bus       (bus[gi]),
            .cap       (cap[gi]),
            .flag      (flag[gi]),
            .lock      (lock[gi]),
            .stb       (stb[gi])
        );
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:    rdata = ctrl_q;
            A_STAT:    rdata[N_CH-1:0] = flag;
            A_CAP1_HI: rdata = cap[0][15:8];
            A_CAP1_LO: rdata = cap[0][7:0];
            A_CAP2_HI: rdata = cap[1][15:8];
            A_CAP2_LO: rdata = cap[1][7:0];
            default:   rdata = '0;
        endcase
    end

    assign irq = (|flag) && ctrl_q.ien && !irq_mask;

endmodule

// File: rtl/icap_dual_chk.sv
module icap_dual_chk
    import icap_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       irq_mask,
    input logic       pulse_mode,
    input logic [1:0] flag,
    input logic [1:0] lock,
    input logic [1:0] stb,
    input logic [1:0] acc_lo,
    input cnt_t       cap0,
    input cnt_t       cap1
);

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (flag == 2'b00 && !irq));

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!irq_mask && flag != 2'b00));

    a_r9_ch1_quiet: assert property (@(posedge clk) disable iff (rst)
        pulse_mode |=> (cap0 == $past(cap0)));

    a_r6_lock_hold0: assert property (@(posedge clk) disable iff (rst)
        lock[0] |=> $stable(cap0));

    a_r6_lock_hold1: assert property (@(posedge clk) disable iff (rst)
        lock[1] |=> $stable(cap1));

    a_r4_flag_source0: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[0]) |-> $past(stb[0]));

    a_r4_flag_source1: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[1]) |-> $past(stb[1]));

    a_r5_clear_path0: assert property (@(posedge clk) disable iff (rst)
        $fell(flag[0]) |-> ($past(acc_lo[0]) && !$past(stb[0])));

    a_r5_clear_path1: assert property (@(posedge clk) disable iff (rst)
        $fell(flag[1]) |-> ($past(acc_lo[1]) && !$past(stb[1])));

    a_r7_capture_wins: assert property (@(posedge clk) disable iff (rst)
        (stb != 2'b00 && acc_lo != 2'b00) |=> ((flag & $past(stb)) == $past(stb)));

endmodule

bind icap_dual icap_dual_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .irq        (irq),
    .irq_mask   (irq_mask),
    .pulse_mode (pulse_mode),
    .flag       (flag),
    .lock       (lock),
    .stb        (stb),
    .acc_lo     ({bus[1].acc_lo, bus[0].acc_lo}),
    .cap0       (cap[0]),
    .cap1       (cap[1])
);

// File: tb/test_icap_dual.sv
`timescale 1ns/1ps
module test_icap_dual;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_a = 1'b0, pin_b = 1'b0;
    logic       pulse_mode = 1'b0, irq_mask = 1'b0;
    logic [2:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    icap_dual i_icap_dual (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
        .pulse_mode(pulse_mode), .irq_mask(irq_mask), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // counter model from R1: value after each non-reset edge, kept in a ring
    logic [15:0] mc;
    logic [3:0]  mp;
    logic [7:0]  mctrl;
    int          nedge;
    logic [15:0] hist [32];

    function automatic int div_model(input logic [1:0] s);
        return (s == 2'b00) ? 4 : (s == 2'b01) ? 2 : 8;
    endfunction

    always @(posedge clk) begin : model
        logic [15:0] nc;
        if (rst) begin
            mc <= 16'hFFFC; mp <= '0; mctrl <= '0; nedge <= 0;
            hist[0] <= 16'hFFFC;
        end else begin
            nc = mc;
            if (int'(mp) >= div_model(mctrl[3:2]) - 1) begin
                mp <= '0; nc = mc + 16'd1;
            end else begin
                mp <= mp + 4'd1;
            end
            mc <= nc;
            hist[(nedge + 1) % 32] <= nc;
            nedge <= nedge + 1;
            if (wr_en && addr == 3'd0) mctrl <= wdata;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd16(input int ch, output logic [15:0] v);
        logic [7:0] h, l;
        rd(ch ? 3'd4 : 3'd2, h);
        rd(ch ? 3'd5 : 3'd3, l);
        v = {h, l};
    endtask

    task automatic setlvl(input int ch, input logic v);
        @(negedge clk);
        if (ch == 0) pin_a = v; else pin_b = v;
    endtask

    task automatic edge_at(input int ch, input logic v, output int m);
        @(negedge clk);
        if (ch == 0) pin_a = v; else pin_b = v;
        m = nedge;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0]  d;
        logic [15:0] v, vkeep;
        int          m;
        void'($urandom(32'd1234));
        cyc(4);
        rst = 1'b0;

        // R11 reset state
        rd(3'd0, d); chk("R11 ctrl", d, 0);
        rd(3'd1, d); chk("R11 stat", d, 0);
        rd16(0, v);  chk("R11 cap1", v, 0);
        #1 chk("R11 irq", irq, 0);

        // R3: rising edge ignored with falling selected; R1 first capture
        setlvl(0, 1'b1); cyc(5);
        rd(3'd1, d); chk("R3 no flag on wrong edge", d[0], 0);
        edge_at(0, 1'b0, m); cyc(5);
        rd(3'd1, d); chk("R4 flag set", d[0], 1);
        rd16(0, v);  chk("R1 count from reset", v, 16'(32'hFFFC + (m + 2) / 4));
        rd(3'd1, d); chk("R5 cleared by sequence", d[0], 0);

        // R5: low access without prior status read keeps flag
        setlvl(0, 1'b1); cyc(4);
        edge_at(0, 1'b0, m); cyc(5);
        rd(3'd3, d);
        rd(3'd1, d); chk("R5 no arm keeps flag", d[0], 1);
        rd(3'd3, d);
        rd(3'd1, d); chk("R5 armed clear", d[0], 0);

        // R8 interrupt gating and pending
        setlvl(1, 1'b1); cyc(4);
        edge_at(1, 1'b0, m); cyc(5);
        #1 chk("R8 disabled", irq, 0);
        irq_mask = 1'b1;
        wr(3'd0, 8'h10);
        @(negedge clk); #1 chk("R8 masked", irq, 0);
        irq_mask = 1'b0;
        #1 chk("R8 pending released", irq, 1);
        rd(3'd1, d); rd(3'd5, d);
        @(negedge clk); #1 chk("R8 cleared", irq, 0);

        // R6 lock
        wr(3'd0, 8'h01);
        edge_at(0, 1'b1, m); cyc(5);
        rd(3'd1, d); rd16(0, v);
        chk("R2 rising capture", v, hist[(m + 2) % 32]);
        vkeep = v;
        rd(3'd2, d);
        setlvl(0, 1'b0); cyc(4);
        edge_at(0, 1'b1, m); cyc(5);
        rd(3'd1, d); chk("R6 locked no flag", d[0], 0);
        rd(3'd3, d); chk("R6 locked low byte", d, vkeep[7:0]);
        setlvl(0, 1'b0); cyc(4);
        edge_at(0, 1'b1, m); cyc(5);
        rd(3'd1, d); chk("R6 unlocked flag", d[0], 1);
        rd16(0, v);  chk("R6 unlocked value", v, hist[(m + 2) % 32]);

        // R7 capture in the clearing cycle
        setlvl(0, 1'b0); cyc(4);
        edge_at(0, 1'b1, m); cyc(5);
        setlvl(0, 1'b0); cyc(4);
        rd(3'd1, d);
        edge_at(0, 1'b1, m);
        @(negedge clk);
        rd(3'd3, d);
        cyc(2);
        rd(3'd1, d); chk("R7 flag kept", d[0], 1);
        rd16(0, v);  chk("R7 new value", v, hist[(m + 2) % 32]);
        vkeep = v;
        rd(3'd1, d); chk("R7 later clear", d[0], 0);

        // R10 read-only capture registers
        wr(3'd2, 8'hA5); wr(3'd3, 8'h5A);
        rd16(0, v); chk("R10 write ignored", v, vkeep);

        // R9 pulse mode
        pulse_mode = 1'b1;
        setlvl(0, 1'b0); cyc(4);
        edge_at(0, 1'b1, m); cyc(5);
        rd(3'd1, d); chk("R9 ch1 no flag", d[0], 0);
        rd16(0, v);  chk("R9 ch1 unchanged", v, vkeep);
        setlvl(1, 1'b1); cyc(4);
        edge_at(1, 1'b0, m); cyc(5);
        rd(3'd1, d); chk("R9 ch2 flag", d[1], 1);
        rd16(1, v);  chk("R9 ch2 value", v, hist[(m + 2) % 32]);
        pulse_mode = 1'b0;

        // randomized rounds: channel, polarity, rate, delay
        for (int it = 0; it < 24; it++) begin
            int         ch;
            logic       pol;
            logic [1:0] cs;
            logic [7:0] c;
            ch  = int'($urandom % 2);
            pol = 1'($urandom % 2);
            cs  = 2'($urandom % 4);
            c   = {3'b000, 1'b0, cs, 2'b00};
            c[ch] = pol;
            c[1 - ch] = 1'($urandom % 2);
            wr(3'd0, c);
            setlvl(ch, !pol); cyc(4);
            edge_at(ch, pol, m);
            cyc(5 + int'($urandom % 4));
            rd(3'd1, d); chk("R4 random flag", d[ch], 1);
            rd16(ch, v); chk("R1 R2 random value", v, hist[(m + 2) % 32]);
            rd(3'd1, d); chk("R5 random clear", d[ch], 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule